// File: doc/BRIEF.md
# Fully Registered Stream Interface Buffer

This block sits on a valid/ready stream and cuts every combinational path between the upstream port and the downstream port. Two stages make it up. The input stage holds one spare data register. Because of that register, the ready signal it returns upstream is driven straight from a flip-flop. The output stage keeps the outgoing valid and data in registers.

The output stage loads whenever the downstream side accepts a beat or holds nothing. That load condition is brought out on its own port. External pipeline registers can use it as a clock enable, so they advance in lockstep with the buffer. A beat offered to an idle buffer appears downstream one cycle later. With the downstream side always ready, the buffer moves one beat every clock.

Top module: `stream_reg_slice`

## Requirements
- R1: While `rst` is high, the next rising edge leaves `in_ready` at 1 and `out_valid` at 0.
- R2: `in_ready`, `out_valid` and `out_data` change only at rising clock edges, and each is driven directly by a register.
- R3: `load_en` is 1 exactly when `out_ready` is 1 or `out_valid` is 0.
- R4: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and `out_data` unchanged.
- R5: A beat accepted (`in_valid` and `in_ready` both 1) in a cycle where `load_en` is 1 appears on `out_data` with `out_valid` at 1 in the next cycle.
- R6: With `out_ready` held at 1 and `in_valid` held at 1, one beat is accepted and one beat is delivered on every clock, and `in_ready` stays at 1.
- R7: A beat accepted in a cycle where `load_en` is 0 goes into the spare register, and `in_ready` is 0 in the next cycle.
- R8: Beats leave in the order they were accepted, with none lost and none duplicated. A beat held in the spare register leaves before any later beat.
- R9: When `in_ready` is 0 and `load_en` is 1, the spare register empties into the output stage and `in_ready` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | W | Upstream beat payload |
| in_valid | input | 1 | Upstream beat present |
| in_ready | output | 1 | Buffer can take a beat (registered) |
| out_data | output | W | Downstream beat payload (registered) |
| out_valid | output | 1 | Downstream beat present (registered) |
| out_ready | input | 1 | Downstream takes the beat |
| load_en | output | 1 | Output stage load enable, usable as an external clock enable |

## Verification
The assertions assume that the upstream side never offers a beat while `in_ready` is low and expects it to be taken. A beat held on `in_valid` while `in_ready` is 0 simply waits, and the scoreboard counts a beat only when both signals are 1. The assertions place no rule on `out_ready`, so the stimulus drives it freely, including long stalls and toggling every cycle. Inputs change only on falling edges, so each handshake that the checks and the scoreboard see is the one the design samples.

// File: rtl/stream_reg_slice.sv
module stream_reg_slice #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic         in_ready,
  output logic [W-1:0] out_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         load_en
);

  logic         skid_full;
  logic [W-1:0] skid_q;
  logic         take;
  logic         mid_valid;
  logic [W-1:0] mid_data;

  assign take      = in_valid & in_ready;
  assign load_en   = out_ready | ~out_valid;
  assign mid_valid = skid_full | take;
  assign mid_data  = skid_full ? skid_q : in_data;

  // input stage: ready flop and spare register
  always_ff @(posedge clk) begin
    if (rst) begin
      skid_full <= 1'b0;
      in_ready  <= 1'b1;
    end else begin
      if (load_en)   skid_full <= 1'b0;
      else if (take) skid_full <= 1'b1;
      in_ready <= load_en | ~(skid_full | take);
    end
  end

  always_ff @(posedge clk)
    if (take && !load_en) skid_q <= in_data;

  // output stage
  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (load_en) out_valid <= mid_valid;
  end

  always_ff @(posedge clk)
    if (load_en && mid_valid) out_data <= mid_data;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (in_ready && !out_valid)); // R1

  AST_READY_MATCHES_SKID: assert property (@(posedge clk) disable iff (rst)
    in_ready == !skid_full); // R2

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R4

  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && load_en && !skid_full) |=> (out_valid && out_data == $past(in_data))); // R5

  AST_SKID_FILL_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !load_en) |=> !in_ready); // R7

  AST_SKID_DRAIN_ORDER: assert property (@(posedge clk) disable iff (rst)
    (skid_full && load_en) |=> (out_valid && out_data == $past(skid_q))); // R8

  AST_READY_RETURNS: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && load_en) |=> in_ready); // R9

endmodule

// File: tb/stream_reg_slice_test.sv
module stream_reg_slice_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] in_data;
  logic         in_valid;
  logic         in_ready;
  logic [W-1:0] out_data;
  logic         out_valid;
  logic         out_ready;
  logic         load_en;

  int nchk = 0;
  int nfail = 0;
  logic [W-1:0] expq[$];
  logic         stall_prev = 1'b0;
  logic [W-1:0] stall_data = '0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  stream_reg_slice #(.W(W)) uut (
    .clk(clk), .rst(rst),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .load_en(load_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle at a falling edge, score handshakes, advance to next falling edge
  task automatic step(input logic v, input logic [W-1:0] d, input logic r);
    logic [W-1:0] e;
    in_valid = v; in_data = d; out_ready = r;
    #1;
    chk(load_en == (r | ~out_valid), "R3 load_en", int'(load_en), int'(r | ~out_valid));
    if (stall_prev) begin
      chk(out_valid == 1'b1, "R4 valid held", int'(out_valid), 1);
      chk(out_data == stall_data, "R4 data held", int'(out_data), int'(stall_data));
    end
    stall_prev = out_valid && !out_ready;
    stall_data = out_data;
    if (out_valid && out_ready) begin
      if (expq.size() == 0) chk(1'b0, "R8 extra beat", int'(out_data), 0);
      else begin
        e = expq.pop_front();
        chk(out_data == e, "R8 order", int'(out_data), int'(e));
      end
    end
    if (in_valid && in_ready) expq.push_back(in_data);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    rst = 1'b0;
    stall_prev = 1'b0;
  endtask

  task automatic drain;
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1);
    chk(expq.size() == 0, "R8 drained", expq.size(), 0);
  endtask

  task automatic t_latency;
    step(1'b1, 16'hA5C3, 1'b1);
    chk(out_valid == 1'b1, "R5 valid", int'(out_valid), 1);
    chk(out_data == 16'hA5C3, "R5 data", int'(out_data), 16'hA5C3);
    drain();
  endtask

  task automatic t_stream;
    for (int i = 0; i < 8; i++) begin
      chk(in_ready == 1'b1, "R6 in_ready", int'(in_ready), 1);
      if (i > 0) chk(out_valid == 1'b1, "R6 out_valid", int'(out_valid), 1);
      step(1'b1, 16'h1000 + 16'(i), 1'b1);
    end
    drain();
  endtask

  task automatic t_skid;
    step(1'b1, 16'h00AA, 1'b0);
    chk(in_ready == 1'b1, "R7 ready before fill", int'(in_ready), 1);
    step(1'b1, 16'h00BB, 1'b0);
    chk(in_ready == 1'b0, "R7 ready after fill", int'(in_ready), 0);
    step(1'b1, 16'h00CC, 1'b0);
    chk(in_ready == 1'b0, "R7 ready held", int'(in_ready), 0);
    step(1'b1, 16'h00CC, 1'b1);
    chk(in_ready == 1'b1, "R9 ready back", int'(in_ready), 1);
    chk(out_data == 16'h00BB, "R8 skid first", int'(out_data), 16'h00BB);
    step(1'b1, 16'h00CC, 1'b1);
    drain();
  endtask

  task automatic t_random;
    logic [W-1:0] d = 16'h3000;
    for (int i = 0; i < 400; i++) begin
      logic v = ($urandom % 3) != 0;
      logic r = ($urandom % 2) != 0;
      step(v, d, r);
      if (v && !(expq.size() != 0 && expq[expq.size()-1] != d)) d = d + 16'd1;
    end
    drain();
  endtask

  initial begin
    t_reset();
    t_latency();
    t_stream();
    t_skid();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule